// File: doc/BRIEF.md
# Asynchronous Strobe-Handshake Register Slave

This block lets a host with an asynchronous, strobe-based bus read and write a small bank of 16-bit registers held in a synchronous clock domain. The host frames each access in two phases. In the first phase it pulls the address strobe low with the chip select asserted and presents a 9-bit address. The block latches that address when the strobe returns high. In the second phase it sets the direction line (low for write, high for read) and pulls the data strobe low. The block answers with an acknowledge pulse and then waits for the host to release the data strobe.

All four control inputs pass through two-flop synchronisers. Edges are detected on the synchronised copies. A controller with three states steps through each transfer:

- `ST_IDLE` waits for a qualified data-strobe fall. It moves to `ST_SETTLE` on *start*.
- `ST_SETTLE` counts a settling interval. It moves to `ST_ACK` on *settled* and back to `ST_IDLE` on *abort*, which is an early strobe release.
- `ST_ACK` holds the acknowledge high. It returns to `ST_IDLE` on *release*, which is the data-strobe rise.

On a write, the *release* transition commits the data bus into the addressed register. On a read, the block drives the register onto the data bus only while chip select and the data strobe are both low. It leaves the bus floating at all other times.

Top module: `hostbus_reg_slave`

## Requirements
- R1: On synchronous reset (`rst` high) every register clears to zero, `ack_o` is low and the data bus is not driven.
- R2: A rising edge of `as_n` seen while `cs_n` is low latches `addr_i` as the target address for the following transfers.
- R3: In a write transfer (`rw` low at the data-strobe fall), the value on `data_io` is committed into the addressed register when the data strobe rises, and a later read of that address returns it.
- R4: `ack_o` rises exactly `ACK_DLY`+3 clock cycles after `ds_n` falls (two synchroniser stages, one edge-detect cycle, then `ACK_DLY` settling cycles). It falls three cycles after `ds_n` rises.
- R5: In a read transfer (`rw` high), the block drives the addressed register onto `data_io` only while both `cs_n` and `ds_n` are low.
- R6: A data-strobe fall while `cs_n` is high gives no acknowledge and changes no register.
- R7: A data-strobe fall when no address has been latched since reset gives no acknowledge.
- R8: An address of `NUM_REGS` or above is acknowledged normally. A write to it changes no register, and a read of it returns zero.
- R9: A rising edge of `as_n` while `cs_n` is high discards the latched address. The next data strobe then gives no acknowledge until a new address is latched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| as_n | input | 1 | Address strobe, active low; address taken on its rising edge |
| cs_n | input | 1 | Chip select, active low |
| rw | input | 1 | Direction: 1 = read, 0 = write |
| ds_n | input | 1 | Data strobe, active low |
| addr_i | input | 9 | Register address |
| data_io | inout | 16 | Bidirectional data bus |
| ack_o | output | 1 | Transfer acknowledge, active high |

## Verification
The assertions assume that the host holds `addr_i` steady until the address strobe has been synchronised. They also assume that `rw` and the write data stay steady from the data-strobe fall until `ack_o` has dropped again. The host must not release the data strobe before it sees the acknowledge. The bench drives every input on the falling clock edge and follows this protocol in every transfer. That includes the random mix of reads, writes and out-of-range addresses, and the directed cases that leave chip select high or skip the address phase. The bench waits for the acknowledge to clear before it lets go of the bus.

// File: rtl/hbs_pkg.sv
package hbs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_ACK    = 2'd2
    } hbs_state_e;
endpackage

// File: rtl/hbs_sync.sv
module hbs_sync #(
    parameter int          WIDTH    = 4,
    parameter logic [31:0] RST_BITS = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] d_sync
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic stage1, stage2;
        always_ff @(posedge clk) begin
            if (rst) begin
                stage1 <= RST_BITS[g];
                stage2 <= RST_BITS[g];
            end else begin
                stage1 <= d_async[g];
                stage2 <= stage1;
            end
        end
        assign d_sync[g] = stage2;
    end
endmodule

// File: rtl/hbs_regfile.sv
module hbs_regfile #(
    parameter int NUM_REGS = 16,
    parameter int DW       = 16,
    localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata
);
    logic [DW-1:0] regs [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (we && idx == IDX_W'(g)) begin
                regs[g] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (idx == IDX_W'(i)) rdata = regs[i];
        end
    end
endmodule

// File: rtl/hbs_ctrl.sv
module hbs_ctrl
    import hbs_pkg::*;
#(
    parameter int AW      = 9,
    parameter int ACK_DLY = 2,
    localparam int CW     = $clog2(ACK_DLY + 1) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          as_s,
    input  logic          cs_s,
    input  logic          ds_s,
    input  logic          rw_s,
    input  logic [AW-1:0] addr_raw,
    output logic          ack,
    output logic          wr_commit,
    output logic          rd_active,
    output logic          ds_fall,
    output logic          ds_rise,
    output logic [AW-1:0] addr_q
);
    hbs_state_e state, state_nx;
    logic       as_prev, ds_prev;
    logic       addr_ok;
    logic       cyc_read;
    logic [CW-1:0] cnt;
    logic       as_rise, start, settled;

    assign as_rise = as_s && !as_prev;
    assign ds_fall = !ds_s && ds_prev;
    assign ds_rise = ds_s && !ds_prev;
    assign start   = ds_fall && !cs_s && addr_ok;
    assign settled = (cnt == CW'(ACK_DLY - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            as_prev <= 1'b1;
            ds_prev <= 1'b1;
        end else begin
            as_prev <= as_s;
            ds_prev <= ds_s;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            addr_ok <= 1'b0;
        end else if (as_rise) begin
            if (!cs_s) begin
                addr_q  <= addr_raw;
                addr_ok <= 1'b1;
            end else begin
                addr_ok <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_SETTLE;
            ST_SETTLE: begin
                if (ds_rise)      state_nx = ST_IDLE;
                else if (settled) state_nx = ST_ACK;
            end
            ST_ACK:    if (ds_rise) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            cyc_read <= 1'b0;
        end else if (state == ST_IDLE) begin
            cnt      <= '0;
            cyc_read <= rw_s;
        end else if (state == ST_SETTLE) begin
            cnt <= cnt + CW'(1);
        end
    end

    always_comb begin
        ack       = 1'b0;
        wr_commit = 1'b0;
        rd_active = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_SETTLE: rd_active = cyc_read;
            ST_ACK: begin
                ack       = 1'b1;
                rd_active = cyc_read;
                wr_commit = ds_rise && !cyc_read;
            end
            default:   ;
        endcase
    end
endmodule

// File: rtl/hostbus_reg_slave.sv
module hostbus_reg_slave #(
    parameter int AW       = 9,
    parameter int DW       = 16,
    parameter int NUM_REGS = 16,
    parameter int ACK_DLY  = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          as_n,
    input  logic          cs_n,
    input  logic          rw,
    input  logic          ds_n,
    input  logic [AW-1:0] addr_i,
    inout  wire  [DW-1:0] data_io,
    output logic          ack_o
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam logic [AW-1:0] LIMIT = AW'(NUM_REGS);

    logic [3:0]    sync_q;
    logic          as_s, cs_s, ds_s, rw_s;
    logic          wr_commit, rd_active, ds_fall, ds_rise;
    logic [AW-1:0] addr_q;
    logic          in_range;
    logic [DW-1:0] reg_rdata, rd_data;
    logic          drive_en;

    hbs_sync #(.WIDTH(4), .RST_BITS(32'hF)) sync_i (
        .clk     (clk),
        .rst     (rst),
        .d_async ({as_n, cs_n, ds_n, rw}),
        .d_sync  (sync_q)
    );
    assign {as_s, cs_s, ds_s, rw_s} = sync_q;

    hbs_ctrl #(.AW(AW), .ACK_DLY(ACK_DLY)) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .as_s      (as_s),
        .cs_s      (cs_s),
        .ds_s      (ds_s),
        .rw_s      (rw_s),
        .addr_raw  (addr_i),
        .ack       (ack_o),
        .wr_commit (wr_commit),
        .rd_active (rd_active),
        .ds_fall   (ds_fall),
        .ds_rise   (ds_rise),
        .addr_q    (addr_q)
    );

    assign in_range = (addr_q < LIMIT);

    hbs_regfile #(.NUM_REGS(NUM_REGS), .DW(DW)) rf_i (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_commit && in_range),
        .idx   (addr_q[IDX_W-1:0]),
        .wdata (data_io),
        .rdata (reg_rdata)
    );

    assign rd_data  = in_range ? reg_rdata : '0;
    assign drive_en = rd_active && !cs_n && !ds_n;
    assign data_io  = drive_en ? rd_data : {DW{1'bz}};
endmodule

// File: rtl/hostbus_reg_slave_chk.sv
module hostbus_reg_slave_chk #(
    parameter int ACK_DLY = 2,
    localparam int CW     = $clog2(ACK_DLY + 2) + 2
) (
    input logic clk,
    input logic rst,
    input logic ack_o,
    input logic ds_fall,
    input logic ds_rise,
    input logic cs_s,
    input logic cs_n,
    input logic rw,
    input logic drive_en
);
    logic [CW-1:0] since_fall;
    always_ff @(posedge clk) begin
        if (rst || ds_fall) since_fall <= '0;
        else if (since_fall != '1) since_fall <= since_fall + CW'(1);
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!ack_o && !drive_en));

    a_r4_ack_min_delay: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_o) |-> (since_fall >= CW'(ACK_DLY)));

    a_r4_ack_release: assert property (@(posedge clk) disable iff (rst)
        (ack_o && ds_rise) |=> !ack_o);

    a_r5_drive_needs_cs: assert property (@(posedge clk) disable iff (rst)
        drive_en |-> (!cs_n && rw));

    a_r6_no_ack_unselected: assert property (@(posedge clk) disable iff (rst)
        (ds_fall && cs_s && !ack_o) |=> !ack_o);
endmodule

bind hostbus_reg_slave hostbus_reg_slave_chk #(.ACK_DLY(ACK_DLY)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .ack_o    (ack_o),
    .ds_fall  (ds_fall),
    .ds_rise  (ds_rise),
    .cs_s     (cs_s),
    .cs_n     (cs_n),
    .rw       (rw),
    .drive_en (drive_en)
);

// File: tb/hostbus_reg_slave_tb_top.sv
module hostbus_reg_slave_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NREG       = 16;
    localparam int DLY        = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        as_n = 1'b1, cs_n = 1'b1, rw = 1'b1, ds_n = 1'b1;
    logic [8:0]  addr = '0;
    logic [15:0] host_d = '0;
    logic        host_oe = 1'b0;
    wire  [15:0] data_io;
    logic        ack_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [15:0] model [NREG];

    assign data_io = host_oe ? host_d : 16'hzzzz;
    always #(CLK_PERIOD/2) clk = ~clk;

    hostbus_reg_slave #(.NUM_REGS(NREG), .ACK_DLY(DLY)) dut_i (
        .clk(clk), .rst(rst), .as_n(as_n), .cs_n(cs_n), .rw(rw),
        .ds_n(ds_n), .addr_i(addr), .data_io(data_io), .ack_o(ack_o)
    );

    function automatic logic [15:0] expect_rd(input logic [8:0] a);
        return (a < 9'(NREG)) ? model[a[3:0]] : 16'h0000;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic addr_phase(input logic [8:0] a, input logic sel);
        @(negedge clk);
        cs_n = ~sel; as_n = 1'b0; addr = a;
        repeat (2) @(negedge clk);
        as_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // returns ack latency (0 if none within window) and read data
    task automatic data_phase(input logic wr, input logic [15:0] d, input logic sel,
                              output int lat, output logic [15:0] rd);
        int n;
        @(negedge clk);
        cs_n = ~sel; rw = ~wr; host_d = d; host_oe = wr;
        ds_n = 1'b0;
        lat = 0; rd = '0;
        for (n = 1; n <= 12; n++) begin
            @(negedge clk);
            if (ack_o) begin lat = n; break; end
        end
        if (lat != 0) rd = data_io;
        ds_n = 1'b1;
        if (lat != 0) begin
            n = 0;
            while (ack_o && n < 10) begin @(negedge clk); n++; end
            check("R4 release", 32'(n), 32'd3);
        end
        @(negedge clk);
        cs_n = 1'b1; host_oe = 1'b0; rw = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic full_write(input logic [8:0] a, input logic [15:0] d);
        int lat; logic [15:0] rd;
        addr_phase(a, 1'b1);
        data_phase(1'b1, d, 1'b1, lat, rd);
        check("R4 ack latency (write)", 32'(lat), 32'(DLY + 3));
        if (a < 9'(NREG)) model[a[3:0]] = d;
    endtask

    task automatic full_read(input logic [8:0] a, input string req);
        int lat; logic [15:0] rd;
        addr_phase(a, 1'b1);
        data_phase(1'b0, 16'h0, 1'b1, lat, rd);
        check("R4 ack latency (read)", 32'(lat), 32'(DLY + 3));
        check(req, 32'(rd), 32'(expect_rd(a)));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int lat; logic [15:0] rd;
        int unused_seed;
        for (int i = 0; i < NREG; i++) model[i] = '0;
        unused_seed = $urandom(32'h5EED_1234);
        repeat (4) @(negedge clk);
        check("R1 ack low in reset", 32'(ack_o), 32'd0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R7: strobe without any latched address
        data_phase(1'b1, 16'hDEAD, 1'b1, lat, rd);
        check("R7 no ack before address", 32'(lat), 32'd0);

        // R1: registers zero after reset
        full_read(9'd5, "R1 reset value");
        full_read(9'd15, "R1 reset value top");

        // R2/R3 basic write then read
        full_write(9'd3, 16'hA5C3);
        full_read(9'd3, "R3 write readback");
        full_write(9'd15, 16'hFFFF);
        full_read(9'd15, "R2 address latch top reg");
        full_read(9'd0, "R5 read untouched reg");

        // R6: data strobe without chip select
        addr_phase(9'd3, 1'b1);
        data_phase(1'b1, 16'h1111, 1'b0, lat, rd);
        check("R6 no ack without cs", 32'(lat), 32'd0);
        full_read(9'd3, "R6 register unchanged");

        // R9: address strobe without chip select discards address
        addr_phase(9'd3, 1'b1);
        addr_phase(9'd4, 1'b0);
        data_phase(1'b1, 16'h2222, 1'b1, lat, rd);
        check("R9 no ack after discarded address", 32'(lat), 32'd0);
        full_read(9'd3, "R9 register unchanged");

        // R8: out of range
        full_write(9'd16, 16'h7777);
        full_read(9'd16, "R8 out of range reads zero");
        full_read(9'd0, "R8 no alias into reg 0");
        full_write(9'd511, 16'h8888);
        full_read(9'd511, "R8 top address reads zero");

        // random mix
        for (int k = 0; k < 150; k++) begin
            logic [8:0] a;
            a = 9'($urandom_range(0, NREG + 3));
            if ($urandom_range(0, 1) == 1) full_write(a, 16'($urandom));
            else full_read(a, "R3/R5 random read");
        end
        for (int i = 0; i < NREG; i++) full_read(9'(i), "R3 final sweep");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule